// File: doc/BRIEF.md
# I2C Slave Own-Address Matcher

This unit sits behind an I2C bit-level receiver and decides whether the device is being addressed. The receiver hands it each received byte as a one-cycle strobe, together with START and STOP events. The unit compares the address phase against a programmable own-address register. It answers with an acknowledge request to the bus, a sticky address-match flag, a one-cycle pulse that clears the master-mode state, and an interrupt request.

One register serves both addressing widths. In 7-bit mode only its low seven bits take part. In 10-bit mode the unit first checks the header byte, which carries the two top address bits, and then compares the following byte against the low eight bits. The acknowledge level driven on a match is chosen by software. If the address does not match, the unit stays silent until the next START.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the address register reads back 0x0204 on `regRdata`.
- R2: Bits 15:10 of `regRdata` always read zero; a write of 0xFFFF reads back as 0x03FF.
- R3: In 7-bit mode (`tenBitMode`=0), the first byte after START matches when byte bits 7:1 equal register bits 6:0. Byte bit 0 is R/W and is not compared. Register bits 9:7 have no effect.
- R4: In 10-bit mode, the first byte is acknowledged (without a match) when bits 7:3 are 11110, bits 2:1 equal register bits 9:8, and bit 0 is 0. The next byte is a match when it equals register bits 7:0.
- R5: When `enable` is 0 at a byte strobe, that byte gets no acknowledge and produces no match, and the address phase is abandoned until the next START.
- R6: `ackOe` is high for exactly the one cycle after an acknowledged byte strobe. During that cycle `ackLevel` equals `ackCfg` as sampled at the strobe. At all other times `ackLevel` is 1 (released).
- R7: On a match, `matchFlag` becomes 1 and `clrMaster` pulses high for one cycle. Both appear in the same cycle as `ackOe`.
- R8: `irq` is high exactly when `matchFlag` is 1 and `irqEn` is 1.
- R9: `matchFlag` stays set through later START, STOP and bytes until a `flagClr` pulse. A match in the same cycle as `flagClr` leaves it set.
- R10: After a mismatch, and after a completed match, every later byte gets no acknowledge until the next START.
- R11: A STOP ends the address phase. Bytes received before any START, or after a STOP, are ignored. START has priority over a byte strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startDet | input | 1 | START (or repeated START) seen, one cycle |
| stopDet | input | 1 | STOP seen, one cycle |
| byteValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte, MSB first on the wire |
| enable | input | 1 | Module enable |
| tenBitMode | input | 1 | 1 selects 10-bit addressing |
| ackCfg | input | 1 | Level to drive during acknowledge |
| irqEn | input | 1 | Address-match interrupt enable |
| flagClr | input | 1 | Clears the match flag |
| regWe | input | 1 | Address register write strobe |
| regWdata | input | 16 | Address register write data |
| regRdata | output | 16 | Address register read value |
| ackOe | output | 1 | Drive acknowledge on the bus this cycle |
| ackLevel | output | 1 | SDA level during acknowledge, 1 otherwise |
| matchFlag | output | 1 | Sticky address-match flag |
| clrMaster | output | 1 | One-cycle clear of master-mode state |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit register, a 10-bit address and a 7-bit short address. This keeps each byte space small enough to sweep every value. For three register settings with different top bits, it sweeps all 256 first bytes in 7-bit mode, all 256 header bytes in 10-bit mode, and all 256 second bytes behind a valid header. Each result is compared against a field comparison computed in the bench. Directed sequences then cover enable gating, interrupt gating, flag stickiness against a same-cycle clear, and the STOP and pre-START cases.

// File: rtl/i2c_addr_match_pkg.sv
package i2c_addr_match_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic ackPulse;
    logic matchHit;
  } ctrlStrobe_t;

  // compare results from datapath to control
  typedef struct packed {
    logic hit7;
    logic hitHdr;
    logic hitLow;
  } cmpResult_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_LOW   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;
endpackage

// File: rtl/addr_match_ctrl.sv
module addr_match_ctrl
  import i2c_addr_match_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        byteValid,
  input  logic        enable,
  input  logic        tenBitMode,
  input  cmpResult_t  cmp,
  output ctrlStrobe_t strobe
);
  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    if (startDet) begin
      phaseNext = PH_FIRST;
    end else if (stopDet) begin
      phaseNext = PH_IDLE;
    end else if (byteValid) begin
      case (phase)
        PH_FIRST: begin
          phaseNext = PH_HOLD;
          if (enable) begin
            if (!tenBitMode) begin
              if (cmp.hit7) begin
                strobe.ackPulse = 1'b1;
                strobe.matchHit = 1'b1;
              end
            end else if (cmp.hitHdr) begin
              strobe.ackPulse = 1'b1;
              phaseNext       = PH_LOW;
            end
          end
        end
        PH_LOW: begin
          phaseNext = PH_HOLD;
          if (enable && cmp.hitLow) begin
            strobe.ackPulse = 1'b1;
            strobe.matchHit = 1'b1;
          end
        end
        default: phaseNext = phase;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end
endmodule

// File: rtl/addr_match_dp.sv
module addr_match_dp
  import i2c_addr_match_pkg::*;
#(
  parameter int          REG_W   = 16,
  parameter int          ADDR_W  = 10,
  parameter int          SHORT_W = 7,
  parameter logic [15:0] RST_VAL = 16'h0204
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rxByte,
  input  logic              ackCfg,
  input  logic              irqEn,
  input  logic              flagClr,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regWdata,
  input  ctrlStrobe_t       strobe,
  output cmpResult_t        cmp,
  output logic [REG_W-1:0]  regRdata,
  output logic              ackOe,
  output logic              ackLevel,
  output logic              matchFlag,
  output logic              clrMaster,
  output logic              irq
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int PAD_W = REG_W - ADDR_W;
  localparam logic [4:0] HDR_TAG = 5'b11110;

  logic [ADDR_W-1:0] addrReg;
  logic              ackLvlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrReg <= RST_VAL[ADDR_W-1:0];
    else if (regWe) addrReg <= regWdata[ADDR_W-1:0];
  end

  assign regRdata = {{PAD_W{1'b0}}, addrReg};

  always_comb begin
    cmp.hit7   = (rxByte[7:1] == addrReg[SHORT_W-1:0]);
    cmp.hitHdr = (rxByte[7:3] == HDR_TAG) &&
                 (rxByte[2:1] == addrReg[ADDR_W-1 -: HI_W]) && !rxByte[0];
    cmp.hitLow = (rxByte == addrReg[7:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackOe     <= 1'b0;
      ackLvlQ   <= 1'b1;
      clrMaster <= 1'b0;
      matchFlag <= 1'b0;
    end else begin
      ackOe     <= strobe.ackPulse;
      ackLvlQ   <= strobe.ackPulse ? ackCfg : 1'b1;
      clrMaster <= strobe.matchHit;
      if (strobe.matchHit)  matchFlag <= 1'b1;
      else if (flagClr)     matchFlag <= 1'b0;
    end
  end

  assign ackLevel = ackOe ? ackLvlQ : 1'b1;
  assign irq      = matchFlag & irqEn;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_match_pkg::*;
#(
  parameter int          REG_W   = 16,
  parameter int          ADDR_W  = 10,
  parameter int          SHORT_W = 7,
  parameter logic [15:0] RST_VAL = 16'h0204
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startDet,
  input  logic             stopDet,
  input  logic             byteValid,
  input  logic [7:0]       rxByte,
  input  logic             enable,
  input  logic             tenBitMode,
  input  logic             ackCfg,
  input  logic             irqEn,
  input  logic             flagClr,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output logic             ackOe,
  output logic             ackLevel,
  output logic             matchFlag,
  output logic             clrMaster,
  output logic             irq
);
  ctrlStrobe_t strobe;
  cmpResult_t  cmp;

  addr_match_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .byteValid(byteValid), .enable(enable), .tenBitMode(tenBitMode),
    .cmp(cmp), .strobe(strobe)
  );

  addr_match_dp #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .RST_VAL(RST_VAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .ackCfg(ackCfg), .irqEn(irqEn),
    .flagClr(flagClr), .regWe(regWe), .regWdata(regWdata), .strobe(strobe),
    .cmp(cmp), .regRdata(regRdata), .ackOe(ackOe), .ackLevel(ackLevel),
    .matchFlag(matchFlag), .clrMaster(clrMaster), .irq(irq)
  );
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk #(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             byteValid,
  input logic             enable,
  input logic             irqEn,
  input logic             flagClr,
  input logic [REG_W-1:0] regRdata,
  input logic             ackOe,
  input logic             ackLevel,
  input logic             matchFlag,
  input logic             clrMaster,
  input logic             irq
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[REG_W-1:ADDR_W] == '0);

  assert_ack_after_byte_R6: assert property (@(posedge clk) disable iff (!rstN)
    ackOe |-> $past(byteValid));

  assert_ack_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackOe |-> $past(enable));

  assert_released_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ackOe |-> ackLevel);

  assert_flag_with_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> clrMaster && ackOe);

  assert_clear_sets_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    clrMaster |-> matchFlag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    matchFlag && !flagClr |=> matchFlag);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqEn);
endmodule

bind i2c_addr_match i2c_addr_match_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .enable(enable),
  .irqEn(irqEn), .flagClr(flagClr), .regRdata(regRdata), .ackOe(ackOe),
  .ackLevel(ackLevel), .matchFlag(matchFlag), .clrMaster(clrMaster), .irq(irq)
);

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  logic        clk = 0;
  logic        rstN = 0;
  logic        startDet = 0, stopDet = 0, byteValid = 0;
  logic [7:0]  rxByte = '0;
  logic        enable = 1, tenBitMode = 0, ackCfg = 0, irqEn = 0, flagClr = 0;
  logic        regWe = 0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        ackOe, ackLevel, matchFlag, clrMaster, irq;

  int checks = 0;
  int errors = 0;
  logic [9:0] cfgs [3] = '{10'h204, 10'h3AB, 10'h0D5};

  always #5 clk = ~clk;

  i2c_addr_match i_i2c_addr_match (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .byteValid(byteValid), .rxByte(rxByte), .enable(enable),
    .tenBitMode(tenBitMode), .ackCfg(ackCfg), .irqEn(irqEn), .flagClr(flagClr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata), .ackOe(ackOe),
    .ackLevel(ackLevel), .matchFlag(matchFlag), .clrMaster(clrMaster), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startDet = 1;
    @(negedge clk) startDet = 0;
  endtask

  task automatic pulseStop();
    @(negedge clk) stopDet = 1;
    @(negedge clk) stopDet = 0;
  endtask

  task automatic pulseClr();
    @(negedge clk) flagClr = 1;
    @(negedge clk) flagClr = 0;
  endtask

  // returns at the negedge where the registered response is visible
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk) begin byteValid = 1; rxByte = b; end
    @(negedge clk) byteValid = 0;
  endtask

  task automatic writeReg(input logic [15:0] v);
    @(negedge clk) begin regWe = 1; regWdata = v; end
    @(negedge clk) regWe = 0;
  endtask

  function automatic bit exp7(input logic [9:0] r, input logic [7:0] b);
    return b[7:1] == r[6:0];
  endfunction

  function automatic bit expHdr(input logic [9:0] r, input logic [7:0] b);
    return b[7:3] == 5'b11110 && b[2:1] == r[9:8] && b[0] == 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(regRdata == 16'h0204, "R1 reset value", regRdata, 16'h0204);
    check(ackLevel == 1 && ackOe == 0, "R6 released after reset", {ackOe, ackLevel}, 2'b01);
    check(matchFlag == 0 && irq == 0, "R8 idle after reset", {matchFlag, irq}, 0);

    writeReg(16'hFFFF);
    check(regRdata == 16'h03FF, "R2 reserved bits", regRdata, 16'h03FF);

    for (int c = 0; c < 3; c++) begin
      writeReg({6'b0, cfgs[c]});
      // R3: 7-bit sweep
      tenBitMode = 0;
      for (int b = 0; b < 256; b++) begin
        logic [7:0] bb;
        bit e;
        bb = 8'(b);
        e  = exp7(cfgs[c], bb);
        ackCfg = bb[3];
        pulseClr();
        pulseStart();
        sendByte(bb);
        check(ackOe == e, "R3 7-bit ack", ackOe, e);
        if (e) check(ackLevel == bb[3], "R6 ack level", ackLevel, bb[3]);
        check(clrMaster == e && matchFlag == e, "R7 match outputs",
              {clrMaster, matchFlag}, {e, e});
        sendByte(bb);
        check(ackOe == 0, "R10 silent after decision", ackOe, 0);
        check(ackLevel == 1, "R6 released", ackLevel, 1);
        pulseStop();
      end
      // R4: header sweep
      tenBitMode = 1;
      ackCfg = 0;
      for (int b = 0; b < 256; b++) begin
        logic [7:0] bb;
        bit e;
        bb = 8'(b);
        e  = expHdr(cfgs[c], bb);
        pulseClr();
        pulseStart();
        sendByte(bb);
        check(ackOe == e, "R4 header ack", ackOe, e);
        check(matchFlag == 0 && clrMaster == 0, "R4 header no match",
              {matchFlag, clrMaster}, 0);
        pulseStop();
      end
      // R4: second byte sweep behind a valid header
      for (int s = 0; s < 256; s++) begin
        logic [7:0] ss;
        bit e;
        ss = 8'(s);
        e  = (ss == cfgs[c][7:0]);
        pulseClr();
        pulseStart();
        sendByte({5'b11110, cfgs[c][9:8], 1'b0});
        sendByte(ss);
        check(ackOe == e && matchFlag == e && clrMaster == e, "R4 low byte",
              {ackOe, matchFlag, clrMaster}, {e, e, e});
        pulseStop();
      end
    end

    // config 10'h0D5: 7-bit address 0x55, first byte 0xAA; low byte 0xD5
    tenBitMode = 0;
    pulseClr();
    enable = 0;
    pulseStart();
    sendByte(8'hAA);
    check(ackOe == 0 && matchFlag == 0, "R5 disabled", {ackOe, matchFlag}, 0);
    enable = 1;
    sendByte(8'hAA);
    check(ackOe == 0, "R5 phase abandoned", ackOe, 0);
    pulseStop();

    // R11: byte without START, then after STOP
    sendByte(8'hAA);
    check(ackOe == 0 && matchFlag == 0, "R11 no START", {ackOe, matchFlag}, 0);
    // R11: START and byte same cycle -> START wins, byte ignored
    @(negedge clk) begin startDet = 1; byteValid = 1; rxByte = 8'hAA; end
    @(negedge clk) begin startDet = 0; byteValid = 0; end
    check(ackOe == 0, "R11 START priority", ackOe, 0);
    sendByte(8'hAA);
    check(ackOe == 1, "R11 first byte after START", ackOe, 1);

    // R8 gating
    irqEn = 0;
    #1 check(irq == 0, "R8 irq masked", irq, 0);
    irqEn = 1;
    #1 check(irq == 1, "R8 irq raised", irq, 1);

    // R9 stickiness through STOP, START, bytes
    pulseStop();
    pulseStart();
    sendByte(8'h12);
    check(matchFlag == 1, "R9 sticky", matchFlag, 1);
    pulseClr();
    check(matchFlag == 0 && irq == 0, "R9 cleared", {matchFlag, irq}, 0);
    // match in same cycle as clear
    pulseStart();
    @(negedge clk) begin byteValid = 1; rxByte = 8'hAB; flagClr = 1; end
    @(negedge clk) begin byteValid = 0; flagClr = 0; end
    check(matchFlag == 1 && ackOe == 1, "R9 set wins", {matchFlag, ackOe}, 2'b11);
    irqEn = 0;

    // R10: mismatch then repeated START recovers
    pulseClr();
    pulseStart();
    sendByte(8'h20);
    sendByte(8'hAA);
    check(ackOe == 0, "R10 ignore after mismatch", ackOe, 0);
    pulseStart();
    sendByte(8'hAA);
    check(ackOe == 1 && matchFlag == 1, "R10 recover on START", {ackOe, matchFlag}, 2'b11);

    // R11: STOP between 10-bit header and low byte
    tenBitMode = 1;
    pulseClr();
    pulseStart();
    sendByte(8'hF0);
    check(ackOe == 1, "R11 header acked", ackOe, 1);
    pulseStop();
    sendByte(8'hD5);
    check(ackOe == 0 && matchFlag == 0, "R11 STOP ends phase", {ackOe, matchFlag}, 0);
    // R10: wrong header then right low byte
    pulseStart();
    sendByte(8'hF2);
    sendByte(8'hD5);
    check(ackOe == 0 && matchFlag == 0, "R10 bad header", {ackOe, matchFlag}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule